// File: doc/BRIEF.md
# Maskable Interrupt Status Unit

This unit gathers eight single-cycle event pulses from a serial flash controller into sticky status bits and combines them into one interrupt line. Each event is recorded in a raw status register whatever the mask says. A mask register decides which recorded events may raise the interrupt. Software reads a masked view to see which enabled sources are pending. It acknowledges sources by writing ones to a clear register.

Access uses a simple 32-bit register bus. The bus has an enable, a write strobe, a word address and write data. Read data is combinational and valid in the same cycle as the enable. Because raw status keeps latching while a source is masked, software should write all ones to the clear register after reset, before it unmasks anything.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the mask register reads 0xFF, the raw status register reads 0x00, the masked status register reads 0x00, and `irq` is low.
- R2: A one-cycle pulse on `evt_pulse[i]` sets raw status bit i from the next clock edge, whether or not mask bit i is set. The bit assignment is: 0 receive full, 1 receive underflow, 2 transmit overflow, 3 transmit empty, 4 transfer finished, 5 bus error, 6 protocol error, 7 DMA done.
- R3: Writing the clear register (offset 0x4) clears every raw status bit whose write-data bit is 1. Write-data bits that are 0 leave their raw bits unchanged.
- R4: When an event pulse and a clear of the same bit occur in the same cycle, the bit ends up set.
- R5: The masked status register (offset 0x8) reads raw status AND NOT mask. The raw status register (offset 0xC) reads the unmasked bits. Both occupy bits 7:0, and the upper bits read as zero.
- R6: `irq` is high exactly when at least one raw status bit is set whose mask bit is 0. A mask bit of 1 blocks its source.
- R7: The mask register (offset 0x0, bits 7:0) is read/write. The clear register reads as zero. Writes to offsets 0x8 and 0xC have no effect, and unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access enable |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_en` is high and `bus_wr` is low |
| evt_pulse | input | 8 | One-cycle event pulses, one bit per source |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is an event and an acknowledge of the same bit landing on the same clock edge. A bench that pulses events and writes registers in separate calls never lines the two up. A dedicated task therefore drives the event pulse and the clear-register write at the same falling edge. It sets a neighbouring bit in the same clear word and leaves that bit already pending, so one cycle shows both outcomes: the colliding bit survives and the neighbour is cleared. The bench also walks a single unmasked source across all eight positions, which confirms the bit order and checks that a masked bit does not leak into the interrupt.

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
  parameter int NUM_SRC  = 8,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_SRC-1:0] evt_pulse,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] OFS_MASK  = ADDR_W'(4'h0);
  localparam logic [ADDR_W-1:0] OFS_CLEAR = ADDR_W'(4'h4);
  localparam logic [ADDR_W-1:0] OFS_PEND  = ADDR_W'(4'h8);
  localparam logic [ADDR_W-1:0] OFS_RAW   = ADDR_W'(4'hC);
  localparam int PAD_W = DATA_W - NUM_SRC;

  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] raw_q;
  logic [NUM_SRC-1:0] ack_vec;
  logic [NUM_SRC-1:0] pending;
  logic               wr_mask;
  logic               wr_clear;

  assign wr_mask  = bus_en && bus_wr && (bus_addr == OFS_MASK);
  assign wr_clear = bus_en && bus_wr && (bus_addr == OFS_CLEAR);
  assign ack_vec  = wr_clear ? bus_wdata[NUM_SRC-1:0] : '0;
  assign pending  = raw_q & ~mask_q;
  assign irq      = |pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      raw_q  <= '0;
    end else begin
      if (wr_mask) mask_q <= bus_wdata[NUM_SRC-1:0];
      raw_q <= (raw_q & ~ack_vec) | evt_pulse;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_wr) begin
      unique case (bus_addr)
        OFS_MASK: bus_rdata = {{PAD_W{1'b0}}, mask_q};
        OFS_PEND: bus_rdata = {{PAD_W{1'b0}}, pending};
        OFS_RAW:  bus_rdata = {{PAD_W{1'b0}}, raw_q};
        default:  bus_rdata = '0;
      endcase
    end
  end

  p_evt_latched_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_pulse) |=> ((raw_q & $past(evt_pulse)) == $past(evt_pulse)));

  p_clear_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clear |=> ((raw_q & $past(bus_wdata[NUM_SRC-1:0]) & ~$past(evt_pulse)) == '0));

  p_raw_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_clear && evt_pulse == '0) |=> $stable(raw_q));

  p_evt_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clear && |(evt_pulse & bus_wdata[NUM_SRC-1:0]))
      |=> ((raw_q & $past(evt_pulse)) == $past(evt_pulse)));

  p_mask_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1) |-> !irq);

  p_mask_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (mask_q == $past(bus_wdata[NUM_SRC-1:0])));

endmodule

// File: tb/test_irq_status_unit.sv
module test_irq_status_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  evt_pulse = '0;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam logic [3:0] A_MASK = 4'h0, A_CLR = 4'h4, A_PEND = 4'h8, A_RAW = 4'hC;

  irq_status_unit i_irq_status_unit (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_pulse(evt_pulse), .irq(irq));

  always #10 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_reg(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #3 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic pulse(logic [7:0] e);
    @(negedge clk);
    evt_pulse = e;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd_reg(A_MASK, d); check("R1 mask", d, 32'hFF);
    rd_reg(A_RAW, d);  check("R1 raw", d, 32'h0);
    rd_reg(A_PEND, d); check("R1 pending", d, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_latch_masked();
    logic [31:0] d;
    pulse(8'h21);
    rd_reg(A_RAW, d);  check("R2 raw latches while masked", d, 32'h21);
    rd_reg(A_PEND, d); check("R5 pending all masked", d, 32'h0);
    check("R6 irq blocked", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_unmask();
    logic [31:0] d;
    wr_reg(A_MASK, 32'hFE);
    rd_reg(A_MASK, d); check("R7 mask readback", d, 32'hFE);
    rd_reg(A_PEND, d); check("R5 pending", d, 32'h01);
    rd_reg(A_RAW, d);  check("R5 raw unmasked view", d, 32'h21);
    check("R6 irq raised", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr_reg(A_CLR, 32'h01);
    rd_reg(A_RAW, d); check("R3 clear bit0", d, 32'h20);
    check("R6 irq dropped", {31'b0, irq}, 32'h0);
    wr_reg(A_CLR, 32'h0);
    rd_reg(A_RAW, d); check("R3 zero write no effect", d, 32'h20);
    wr_reg(A_CLR, 32'hFFFF_FFFF);
    rd_reg(A_RAW, d); check("R3 clear all", d, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    pulse(8'h04);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = A_CLR; bus_wdata = 32'h84;
    evt_pulse = 8'h80;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0; bus_wdata = '0; evt_pulse = '0;
    rd_reg(A_RAW, d); check("R4 event wins over clear", d, 32'h80);
    wr_reg(A_CLR, 32'hFF);
    rd_reg(A_RAW, d); check("R3 cleared after collision", d, 32'h0);
  endtask

  task automatic t_each_bit();
    logic [31:0] d;
    for (int i = 0; i < 8; i++) begin
      wr_reg(A_MASK, ~(32'h1 << i) & 32'hFF);
      pulse(8'(1 << ((i + 1) % 8)));
      check("R6 masked neighbour no irq", {31'b0, irq}, 32'h0);
      pulse(8'(1 << i));
      rd_reg(A_PEND, d); check("R2 bit position", d, 32'h1 << i);
      check("R6 single source irq", {31'b0, irq}, 32'h1);
      wr_reg(A_CLR, 32'hFF);
    end
    wr_reg(A_MASK, 32'hFF);
  endtask

  task automatic t_readonly();
    logic [31:0] d;
    wr_reg(A_RAW, 32'hFF);
    wr_reg(A_PEND, 32'hFF);
    rd_reg(A_RAW, d);  check("R7 status writes ignored", d, 32'h0);
    rd_reg(A_MASK, d); check("R7 mask untouched", d, 32'hFF);
    rd_reg(A_CLR, d);  check("R7 clear reads zero", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_latch_masked();
    t_unmask();
    t_clear();
    t_collide();
    t_each_bit();
    t_readonly();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule